// File: doc/BRIEF.md
# Duty-Cycled Power Wake Controller

This controller runs inside a system that cuts its own supply and relies on an external timer to restore it. It keeps a small power-cycle count on external storage pins, which hold their level while the supply is off. Each time the supply comes back, the controller reads that count. If the count is below its top value, the controller writes back the count plus one and switches itself off again. If the count is at its top value, the controller enables the external sample-and-transmit task, waits for the task to report completion, and then writes back zero. The task therefore runs once in every eight power cycles.

While the supply is up, the controller drives a power-hold output low to keep the supply switch closed and drives a charge output high. At the end of every cycle it holds the storage pins for a fixed save time. It then enters power-down, where it lets go of every output it controls. A manual switch on the reset input powers the system up, clears the count and starts an active cycle.

The power-on input `por_n` stands for the supply ramping up: every flop restarts when it rises. The tri-stated pins are modelled as a value plus an output-enable.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: During the settle window after `por_n` rises, `hold_oe`=1 with `hold_o`=0, `chg_oe`=1 with `chg_o`=1, and `task_en`=0 and `store_oe`=0.
- R2: If the synchronised manual reset is low when the settle window ends, or low in any later state, the controller enters a reset state. There it clears the count, keeps `task_en`=0 and `store_oe`=0, and keeps driving hold and charge. When the manual reset goes high, the controller enters the enable state.
- R3: `task_en` is 1 only in the enable state and 0 in every other state.
- R4: In the enable state, only a low-to-high change of the synchronised `done_i` moves the controller to save. A `done_i` that is already high on entry, or that changes in any other state, has no effect.
- R5: In the save state, `store_oe`=1 and `store_o[i]` carries bit i of the count. The state lasts exactly SAVE_CYC clock cycles (default 440, which is 100 µs at 4.4 MHz). `store_oe` is 0 in every other state.
- R6: After save, the controller enters power-down. There `hold_oe`, `chg_oe`, `store_oe` and `task_en` are all 0. It stays there regardless of `done_i` until `por_n` falls or the manual reset goes low.
- R7: A sampled stored value v below 7 leads directly to save with the count v+1, and `task_en` stays 0 for the whole cycle.
- R8: A sampled stored value of 7 leads to the enable state. The count wraps to 0, and 0 is what the following save writes.
- R9: `store_i` passes through a two-flop synchroniser and is read after a settle window of SETTLE_CYC cycles (default 4). On the increment path, `store_oe` rises at the (SETTLE_CYC+1)-th clock edge after `por_n` rises.
- R10: When each written value is fed back as the next stored value, exactly one cycle in every eight consecutive power cycles enables the task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| por_n | input | 1 | Power-on reset, low while the supply is absent |
| rst_sw_n | input | 1 | Manual reset switch, active low |
| done_i | input | 1 | Completion flag from the sample-and-transmit task |
| store_i | input | 3 | Levels read back from the storage pins |
| store_o | output | 3 | Levels driven onto the storage pins |
| store_oe | output | 1 | Output enable for the storage pins |
| hold_o | output | 1 | Power-hold level (low keeps the supply on) |
| hold_oe | output | 1 | Output enable for power-hold |
| chg_o | output | 1 | Charge output level (high) |
| chg_oe | output | 1 | Output enable for the charge output |
| task_en | output | 1 | Enable for the sample-and-transmit task |

## Verification
The hardest case to reach from the ports is the wrap from 7 to 0 carried across power losses. It appears only after a chain of complete power cycles, and each cycle ends in power-down. The bench models the storage pins: it captures `store_o` during save and presents it as `store_i` at the next `por_n` pulse. Running sixteen cycles in this way checks every increment and both wraps. A separate sweep starts from each of the eight stored values directly, and further runs hold `done_i` high on entry to the enable state and pull the manual reset low in the middle of a cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_RESET  = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_ENABLE = 3'd3,
    ST_SAVE   = 3'd4,
    ST_PWRDN  = 3'd5
  } pwc_state_e;
endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer #(
  parameter int SETTLE_CYC = 4,
  parameter int SAVE_CYC   = 440
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic sel_save,
  output logic expired
);
  localparam int MAXC = (SAVE_CYC > SETTLE_CYC) ? SAVE_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last    = sel_save ? CW'(SAVE_CYC - 1) : CW'(SETTLE_CYC - 1);
  assign expired = run && (cnt == last);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end

  // R5: the counter never runs past the selected limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!por_n)
    run |-> (cnt <= last));
endmodule

// File: rtl/pwc_fsm.sv
module pwc_fsm
  import pwc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_s,
  input  logic             done_s,
  input  logic [CNT_W-1:0] store_s,
  input  logic             tmr_exp,
  output pwc_state_e       state,
  output logic [CNT_W-1:0] count,
  output logic             tmr_run,
  output logic             tmr_sel_save,
  output logic             done_rise
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  function automatic logic cnt_at_top(input logic [CNT_W-1:0] v);
    return v == LAST;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] v);
    return cnt_at_top(v) ? '0 : v + CNT_W'(1);
  endfunction

  pwc_state_e       state_nx;
  logic [CNT_W-1:0] count_nx;
  logic             done_q;

  assign done_rise    = done_s && !done_q;
  assign tmr_run      = (state == ST_PWRUP) || (state == ST_SAVE);
  assign tmr_sel_save = (state == ST_SAVE);

  always_comb begin
    state_nx = state;
    count_nx = count;
    if (state != ST_PWRUP && !rst_s) begin
      state_nx = ST_RESET;
      count_nx = '0;
    end else begin
      unique case (state)
        ST_PWRUP:  if (tmr_exp) state_nx = rst_s ? ST_SAMPLE : ST_RESET;
        ST_RESET:  state_nx = ST_ENABLE;
        ST_SAMPLE: begin
          count_nx = cnt_next(store_s);
          state_nx = cnt_at_top(store_s) ? ST_ENABLE : ST_SAVE;
        end
        ST_ENABLE: if (done_rise) state_nx = ST_SAVE;
        ST_SAVE:   if (tmr_exp) state_nx = ST_PWRDN;
        ST_PWRDN:  state_nx = ST_PWRDN;
        default:   state_nx = ST_PWRDN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= ST_PWRUP;
      count  <= '0;
      done_q <= 1'b0;
    end else begin
      state  <= state_nx;
      count  <= count_nx;
      done_q <= done_s;
    end
  end

  // R7: a stored value below the top is incremented and saved
  p_incr_r7: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_SAMPLE && rst_s && store_s != LAST)
      |=> (state == ST_SAVE && count == $past(store_s) + CNT_W'(1)));

  // R8: the top value leads to enable with the count wrapped to zero
  p_wrap_r8: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_SAMPLE && rst_s && store_s == LAST)
      |=> (state == ST_ENABLE && count == '0));

  // R4: without a rising done the enable state is kept
  p_done_edge_r4: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_ENABLE && rst_s && !done_rise) |=> (state == ST_ENABLE));

  // R5: the saved value does not change during the save hold
  p_save_stable_r5: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_SAVE && rst_s) |=> $stable(count));

  // R6: power-down is left only by the manual reset
  p_pwrdn_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (state == ST_PWRDN && rst_s) |=> (state == ST_PWRDN));

  // R2: a low manual reset after the settle window forces the reset state
  p_manual_rst_r2: assert property (@(posedge clk) disable iff (!por_n)
    (state != ST_PWRUP && !rst_s) |=> (state == ST_RESET && count == '0));
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwc_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int SETTLE_CYC = 4,
  parameter int SAVE_CYC   = 440
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_sw_n,
  input  logic             done_i,
  input  logic [CNT_W-1:0] store_i,
  output logic [CNT_W-1:0] store_o,
  output logic             store_oe,
  output logic             hold_o,
  output logic             hold_oe,
  output logic             chg_o,
  output logic             chg_oe,
  output logic             task_en
);
  localparam int SW = CNT_W + 2;

  logic [SW-1:0]    sync_d;
  logic [SW-1:0]    sync_q;
  logic             rst_s;
  logic             done_s;
  logic [CNT_W-1:0] store_s;
  logic             tmr_run;
  logic             tmr_sel_save;
  logic             tmr_exp;
  logic             done_rise;
  logic [CNT_W-1:0] count;
  pwc_state_e       state;

  assign sync_d = {rst_sw_n, done_i, store_i};
  assign {rst_s, done_s, store_s} = sync_q;

  pwc_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk(clk), .por_n(por_n), .d(sync_d), .q(sync_q)
  );

  pwc_timer #(.SETTLE_CYC(SETTLE_CYC), .SAVE_CYC(SAVE_CYC)) u_timer (
    .clk(clk), .por_n(por_n), .run(tmr_run),
    .sel_save(tmr_sel_save), .expired(tmr_exp)
  );

  pwc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .por_n(por_n), .rst_s(rst_s), .done_s(done_s),
    .store_s(store_s), .tmr_exp(tmr_exp), .state(state), .count(count),
    .tmr_run(tmr_run), .tmr_sel_save(tmr_sel_save), .done_rise(done_rise)
  );

  assign hold_o   = 1'b0;
  assign chg_o    = 1'b1;
  assign hold_oe  = (state != ST_PWRDN);
  assign chg_oe   = (state != ST_PWRDN);
  assign task_en  = (state == ST_ENABLE);
  assign store_oe = (state == ST_SAVE);
  assign store_o  = store_oe ? count : '0;

  // R6: once the power hold is released every other output is released too
  p_release_all_r6: assert property (@(posedge clk) disable iff (!por_n)
    !hold_oe |-> (!chg_oe && !store_oe && !task_en));

  // R3: the task is never enabled while the storage pins are driven
  p_en_excl_r3: assert property (@(posedge clk) disable iff (!por_n)
    !(task_en && store_oe));
endmodule

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
  localparam int SETTLE = 4;
  localparam int SAVE   = 440;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_sw_n = 1'b1;
  logic       done_i = 1'b0;
  logic [2:0] store_i = 3'd0;
  logic [2:0] store_o;
  logic       store_oe, hold_o, hold_oe, chg_o, chg_oe, task_en;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pwr_wake_ctrl #(.CNT_W(3), .SETTLE_CYC(SETTLE), .SAVE_CYC(SAVE)) u_pwr_wake_ctrl (
    .clk(clk), .por_n(por_n), .rst_sw_n(rst_sw_n), .done_i(done_i),
    .store_i(store_i), .store_o(store_o), .store_oe(store_oe),
    .hold_o(hold_o), .hold_oe(hold_oe), .chg_o(chg_o), .chg_oe(chg_oe),
    .task_en(task_en)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_power(input logic [2:0] v, input logic sw_n, input logic dn);
    @(negedge clk);
    por_n = 1'b0; store_i = v; rst_sw_n = sw_n; done_i = dn;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  // One normal cycle; pulses done when the task is enabled.
  task automatic run_cycle(input logic [2:0] v, output bit saw_en,
                           output int wr, output int lat, output int slen);
    int n;
    int bad;
    saw_en = 0; slen = 0; bad = 0;
    start_power(v, 1'b1, 1'b0);
    @(negedge clk); n = 1;
    chk("R1", {hold_oe, hold_o, chg_oe, chg_o, task_en, store_oe}, 6'b101100, "powerup outputs");
    while (!store_oe && n < 3000) begin
      if (task_en && !saw_en) begin saw_en = 1; done_i = 1'b1; end
      @(negedge clk); n++;
    end
    lat = n;
    wr = store_o;
    while (store_oe && slen < 3000) begin
      if (store_o != wr[2:0] || task_en) bad++;
      @(negedge clk); slen++;
    end
    chk("R5", bad, 0, "save value stable and task off");
    chk("R6", {hold_oe, chg_oe, store_oe, task_en}, 0, "released after save");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit   en;
    int   wr, lat, slen, enables, n, bad;
    logic [2:0] carry;

    // Reset state during power-on
    @(negedge clk);
    chk("R1", {hold_oe, chg_oe, task_en, store_oe}, 4'b1100, "outputs under por");

    // Sweep every stored value
    for (int v = 0; v < 8; v++) begin
      run_cycle(3'(v), en, wr, lat, slen);
      chk(v == 7 ? "R8" : "R7", int'(en), int'(v == 7), "task enable");
      chk(v == 7 ? "R8" : "R7", wr, (v + 1) % 8, "written count");
      chk("R5", slen, SAVE, "save length");
      if (v != 7) chk("R9", lat, SETTLE + 1, "latency to save");
    end

    // Power-down ignores done
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); done_i = k[2];
      if (hold_oe || chg_oe || store_oe || task_en) bad++;
    end
    chk("R6", bad, 0, "powerdown holds under done toggles");
    chk("R4", bad, 0, "done ignored in powerdown");

    // Chain of cycles with fed-back storage
    carry = 3'd3; enables = 0;
    for (int c = 0; c < 16; c++) begin
      run_cycle(carry, en, wr, lat, slen);
      enables += int'(en);
      chk("R10", wr, (int'(carry) + 1) % 8, "chained count");
      carry = wr[2:0];
    end
    chk("R10", enables, 2, "enables in sixteen cycles");

    // Done already high on entry to enable
    start_power(3'd7, 1'b1, 1'b1);
    bad = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (store_oe) bad++;
    end
    chk("R4", bad, 0, "held done does not save");
    chk("R3", int'(task_en), 1, "enabled while waiting");
    done_i = 1'b0; repeat (5) @(negedge clk);
    chk("R4", int'(store_oe), 0, "falling done no save");
    done_i = 1'b1; n = 0;
    while (!store_oe && n < 50) begin @(negedge clk); n++; end
    chk("R4", int'(store_oe), 1, "rising done saves");
    chk("R8", int'(store_o), 0, "wrapped value saved");
    chk("R3", int'(task_en), 0, "task off in save");

    // Manual reset at power-up
    start_power(3'd5, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R2", {hold_oe, chg_oe, task_en, store_oe}, 4'b1100, "reset state outputs");
    rst_sw_n = 1'b1; repeat (6) @(negedge clk);
    chk("R2", int'(task_en), 1, "enable after reset release");
    rst_sw_n = 1'b0; repeat (6) @(negedge clk);
    chk("R2", int'(task_en), 0, "reset during enable");
    rst_sw_n = 1'b1; repeat (6) @(negedge clk);
    chk("R3", int'(task_en), 1, "enable again");
    done_i = 1'b1; n = 0;
    while (!store_oe && n < 50) begin @(negedge clk); n++; end
    chk("R2", int'(store_o), 0, "count cleared by reset");
    n = 0;
    while (store_oe && n < 1000) begin @(negedge clk); n++; end
    chk("R6", int'(hold_oe), 0, "powerdown after reset cycle");
    rst_sw_n = 1'b0; repeat (6) @(negedge clk);
    chk("R2", {hold_oe, chg_oe}, 2'b11, "manual reset leaves powerdown");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule